// File: doc/BRIEF.md
# Dual-Mode Cascadable Pulse Accumulator

This block counts activity on a single input pin. In event mode it counts the pin's edges. In gated mode it counts ticks of the system clock divided by 64, but only while the pin sits at a selected level. A polarity bit picks the counted edge in event mode and the gating level in gated mode.

Two byte counters either join into one 16-bit accumulator or run as two separate 8-bit counters. A system-enable bit in the control register chooses between the two. In the joined form an overflow flag and a pin-edge flag can raise interrupts. In the split form each byte counts only when its own external enable input is high.

Software reaches the block through a four-location byte register interface. Writes land on the clock edge and reads are combinational. A 16-bit value is loaded atomically: the high byte is staged first and committed together with the low byte.

Top module: `pulse_acc_top`

## Requirements
- R1: Location 0 is control, 1 the count high byte, 2 the count low byte, 3 the flags. All locations reset to 0. The control byte is fully writable and readable, except bit 7, which always reads 0. Control bits: 6 system enable, 5 mode (1 = gated), 4 polarity, 3:2 clock select, 1 overflow interrupt enable, 0 edge interrupt enable.
- R2: In event mode with polarity 0, each falling pin edge adds exactly one to the count. With polarity 1, each rising edge adds one and the opposite edge adds nothing.
- R3: In gated mode the count advances once per 64 system clocks while the pin is high (polarity 0) or low (polarity 1). A gate lasting exactly 64*K clocks adds exactly K.
- R4: With system enable set, a falling pin edge (polarity 0) or a rising pin edge (polarity 1) sets flag bit 0 in either mode. The edge interrupt output equals flag bit 0 AND control bit 0.
- R5: With system enable set, the bytes form one 16-bit counter: a carry out of the low byte increments the high byte, and the per-byte enable inputs are ignored.
- R6: With system enable clear, each byte counts the selected edge only while its own enable input is high. It wraps at 8 bits with no carry into the other byte, and flag bit 0 is never set.
- R7: When the 16-bit count wraps from 0xFFFF to 0x0000, flag bit 1 is set. The overflow interrupt output equals flag bit 1 AND control bit 1.
- R8: Writing 1 to a bit of the flag location clears that flag. Writing 0 leaves it unchanged.
- R9: With system enable set, a high-byte write is staged and leaves the count unchanged; the next low-byte write loads both bytes at once. With system enable clear, each byte write loads its own byte directly.
- R10: The clock-select bits are stored and read back but have no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register location select |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| lo_cnt_en | input | 1 | Low byte enable, used in split mode |
| hi_cnt_en | input | 1 | High byte enable, used in split mode |
| pin_in | input | 1 | Asynchronous counted pin |
| edge_irq | output | 1 | Pin-edge interrupt |
| ovf_irq | output | 1 | 16-bit overflow interrupt |

## Verification
The hardest case to reach is an exact count in gated mode. The prescaler runs freely and has no visible phase, so the number of ticks inside an arbitrary gate window cannot be predicted from the ports. The stimulus avoids this by holding the pin for a whole multiple of 64 clocks, measured on the falling clock edge. Any such window holds exactly K prescaler ticks, whatever the phase. The overflow wrap is reached by loading 0xFFFF atomically and then applying one counted edge.

// File: rtl/pa_pkg.sv
package pa_pkg;
   localparam logic [1:0] A_CTRL = 2'd0;
   localparam logic [1:0] A_CNTH = 2'd1;
   localparam logic [1:0] A_CNTL = 2'd2;
   localparam logic [1:0] A_FLAG = 2'd3;

   typedef struct packed {
      logic       sys_en;
      logic       gated;
      logic       pol;
      logic [1:0] clk_sel;
      logic       ovf_ie;
      logic       edge_ie;
   } ctrl_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("pa_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/pa_prescale.sv
module pa_prescale #(
   parameter int DIV_BITS = 6
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick
);
   generate
      if (DIV_BITS < 1) begin : g_bad
         $error("pa_prescale needs DIV_BITS >= 1");
      end
   endgenerate

   logic [DIV_BITS-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + 1'b1;
   end

   assign tick = &div_q;

   // R3: a terminal count is never followed directly by another
   p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);
endmodule

// File: rtl/pa_byte_cnt.sv
module pa_byte_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         inc,
   input  logic         ld,
   input  logic [W-1:0] ld_val,
   output logic [W-1:0] cnt,
   output logic         full
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (inc) cnt <= cnt + 1'b1;
   end

   assign full = &cnt;
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
   import pa_pkg::*;
#(
   parameter int BYTE_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PRE_BITS    = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic [BYTE_W-1:0] reg_wdata,
   output logic [BYTE_W-1:0] reg_rdata,
   input  logic              lo_cnt_en,
   input  logic              hi_cnt_en,
   input  logic              pin_in,
   output logic              edge_irq,
   output logic              ovf_irq
);
   localparam int NBYTES = 2;
   localparam int CTRL_W = $bits(ctrl_t);

   generate
      if (BYTE_W < CTRL_W + 1) begin : g_bad_w
         $error("BYTE_W too narrow for the control byte");
      end
   endgenerate

   ctrl_t             ctrl_q;
   logic [BYTE_W-1:0] hold_q;
   logic              edge_flag, ovf_flag;
   logic              pin_s, pin_d;
   logic              tick;

   pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(pin_in), .q(pin_s));

   pa_prescale #(.DIV_BITS(PRE_BITS)) u_pre (
      .clk(clk), .rst_n(rst_n), .tick(tick));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pin_d <= 1'b0;
      else        pin_d <= pin_s;
   end

   logic rise, fall, sel_edge, gate_on, step, split_ev;
   assign rise     = pin_s & ~pin_d;
   assign fall     = ~pin_s & pin_d;
   assign sel_edge = ctrl_q.pol ? rise : fall;
   assign gate_on  = pin_s ^ ctrl_q.pol;
   assign step     = ctrl_q.sys_en & (ctrl_q.gated ? (tick & gate_on) : sel_edge);
   assign split_ev = ~ctrl_q.sys_en & sel_edge;

   logic wr_ctrl, wr_hi, wr_lo, wr_flag;
   assign wr_ctrl = reg_wr && reg_addr == A_CTRL;
   assign wr_hi   = reg_wr && reg_addr == A_CNTH;
   assign wr_lo   = reg_wr && reg_addr == A_CNTL;
   assign wr_flag = reg_wr && reg_addr == A_FLAG;

   logic [NBYTES-1:0][BYTE_W-1:0] cnt, ld_val;
   logic [NBYTES-1:0]             inc, ld, full;

   always_comb begin
      inc[0]    = ctrl_q.sys_en ? step : (lo_cnt_en & split_ev);
      inc[1]    = ctrl_q.sys_en ? (step & full[0]) : (hi_cnt_en & split_ev);
      ld[0]     = wr_lo;
      ld_val[0] = reg_wdata;
      ld[1]     = ctrl_q.sys_en ? wr_lo : wr_hi;
      ld_val[1] = ctrl_q.sys_en ? hold_q : reg_wdata;
   end

   generate
      for (genvar b = 0; b < NBYTES; b++) begin : g_byte
         pa_byte_cnt #(.W(BYTE_W)) u_byte (
            .clk(clk), .rst_n(rst_n), .inc(inc[b]), .ld(ld[b]),
            .ld_val(ld_val[b]), .cnt(cnt[b]), .full(full[b]));
      end
   endgenerate

   logic ovf_set, edge_set;
   assign ovf_set  = ctrl_q.sys_en & step & full[0] & full[1] & ~wr_lo;
   assign edge_set = ctrl_q.sys_en & sel_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         hold_q    <= '0;
         edge_flag <= 1'b0;
         ovf_flag  <= 1'b0;
      end else begin
         if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
         if (wr_hi && ctrl_q.sys_en) hold_q <= reg_wdata;
         edge_flag <= edge_set | (edge_flag & ~(wr_flag & reg_wdata[0]));
         ovf_flag  <= ovf_set  | (ovf_flag  & ~(wr_flag & reg_wdata[1]));
      end
   end

   always_comb begin
      case (reg_addr)
         A_CTRL:  reg_rdata = BYTE_W'({1'b0, ctrl_q});
         A_CNTH:  reg_rdata = cnt[1];
         A_CNTL:  reg_rdata = cnt[0];
         default: reg_rdata = BYTE_W'({ovf_flag, edge_flag});
      endcase
   end

   assign edge_irq = edge_flag & ctrl_q.edge_ie;
   assign ovf_irq  = ovf_flag & ctrl_q.ovf_ie;

   // R7: a counted step from all ones wraps to zero and raises the flag
   p_ovf_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.sys_en && step && full[0] && full[1] && !reg_wr)
      |=> (cnt[0] == '0 && cnt[1] == '0 && ovf_flag));

   // R5: carry out of the low byte moves the high byte
   p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_q.sys_en && step && full[0] && !full[1] && !reg_wr)
      |=> cnt[1] == $past(cnt[1]) + 1'b1);

   // R6: split mode never raises the edge flag
   p_split_no_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q.sys_en && !edge_flag) |=> !edge_flag);

   // R9: a staged high-byte write leaves the count alone
   p_stage_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hi && ctrl_q.sys_en && !step) |=> cnt[1] == $past(cnt[1]));

   // R8: writing 1 clears the overflow flag when no new wrap occurs
   p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_flag && reg_wdata[1] && !ovf_set) |=> !ovf_flag);
endmodule

// File: tb/pulse_acc_top_tb.sv
module pulse_acc_top_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'd0;
   logic [7:0] reg_rdata;
   logic       lo_cnt_en = 1'b0, hi_cnt_en = 1'b0, pin_in = 1'b0;
   logic       edge_irq, ovf_irq;
   int         n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   pulse_acc_top u_dut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lo_cnt_en(lo_cnt_en),
      .hi_cnt_en(hi_cnt_en), .pin_in(pin_in), .edge_irq(edge_irq),
      .ovf_irq(ovf_irq));

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic rd16(output logic [15:0] v);
      logic [7:0] h, l;
      rd(2'd1, h); rd(2'd2, l);
      v = {h, l};
   endtask

   task automatic set_pin(input logic v);
      @(negedge clk); pin_in = v;
      repeat (5) @(negedge clk);
   endtask

   task automatic pulse();
      set_pin(1'b1); set_pin(1'b0);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      for (int a = 0; a < 4; a++) begin
         rd(a[1:0], d);
         chk("R1 reset value", {8'd0, d}, 16'd0);
      end
      chk("R1 reset irqs", {14'd0, edge_irq, ovf_irq}, 16'd0);
   endtask

   task automatic t_ctrl();
      logic [7:0] d;
      wr(2'd0, 8'hFF); rd(2'd0, d);
      chk("R1 ctrl bit7 reads 0", {8'd0, d}, 16'h007F);
      wr(2'd0, 8'h0C); rd(2'd0, d);
      chk("R10 clock select readback", {8'd0, d}, 16'h000C);
      wr(2'd0, 8'h00);
   endtask

   task automatic t_event();
      logic [15:0] v; logic [7:0] f;
      wr(2'd0, 8'h40); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      repeat (3) pulse();
      rd16(v); chk("R2 R5 falling edges counted once, enables ignored", v, 16'd3);
      rd(2'd3, f); chk("R4 edge flag in event mode", {8'd0, f}, 16'h0001);
      wr(2'd0, 8'h50); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h03);
      set_pin(1'b1); rd16(v); chk("R2 rising edge counts with polarity 1", v, 16'd1);
      set_pin(1'b0); rd16(v); chk("R2 falling edge ignored with polarity 1", v, 16'd1);
   endtask

   task automatic t_flags();
      logic [7:0] f;
      wr(2'd3, 8'h00); rd(2'd3, f);
      chk("R8 writing 0 keeps flag", {8'd0, f}, 16'h0001);
      wr(2'd3, 8'h01); rd(2'd3, f);
      chk("R8 writing 1 clears flag", {8'd0, f}, 16'h0000);
      wr(2'd0, 8'h51); set_pin(1'b1);
      chk("R4 edge irq asserted", {15'd0, edge_irq}, 16'd1);
      set_pin(1'b0); wr(2'd3, 8'h01);
      chk("R4 edge irq drops after clear", {15'd0, edge_irq}, 16'd0);
   endtask

   task automatic t_load_ovf();
      logic [7:0] d; logic [15:0] v;
      wr(2'd0, 8'h42); wr(2'd1, 8'h00); wr(2'd2, 8'h00);
      wr(2'd1, 8'hFF); rd(2'd1, d);
      chk("R9 staged high byte not yet loaded", {8'd0, d}, 16'h0000);
      wr(2'd2, 8'hFF); rd16(v);
      chk("R9 atomic 16-bit load", v, 16'hFFFF);
      pulse(); rd16(v);
      chk("R7 wrap to zero", v, 16'h0000);
      rd(2'd3, d); chk("R7 overflow flag set", {8'd0, d}, 16'h0003);
      chk("R7 ovf irq", {14'd0, ovf_irq, edge_irq}, 16'h0002);
      wr(2'd3, 8'h03);
      wr(2'd1, 8'h00); wr(2'd2, 8'hFF); pulse(); rd16(v);
      chk("R5 low byte carry into high byte", v, 16'h0100);
      rd(2'd3, d); chk("R7 no overflow on carry", {8'd0, d & 8'h02}, 16'h0000);
      wr(2'd3, 8'h03);
   endtask

   task automatic t_gated();
      logic [15:0] v; logic [7:0] f;
      wr(2'd0, 8'h60); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h03);
      @(negedge clk); pin_in = 1'b1;
      repeat (64 * 3) @(negedge clk);
      pin_in = 1'b0;
      repeat (5) @(negedge clk);
      rd16(v); chk("R3 gated high level, 3 ticks", v, 16'd3);
      rd(2'd3, f); chk("R4 trailing falling edge sets flag", {8'd0, f}, 16'h0001);
      wr(2'd0, 8'h00); set_pin(1'b1);
      wr(2'd0, 8'h70); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'h03);
      @(negedge clk); pin_in = 1'b0;
      repeat (64 * 2) @(negedge clk);
      pin_in = 1'b1;
      repeat (5) @(negedge clk);
      rd16(v); chk("R3 gated low level, 2 ticks", v, 16'd2);
      rd(2'd3, f); chk("R4 trailing rising edge sets flag", {8'd0, f}, 16'h0001);
      wr(2'd0, 8'h00); set_pin(1'b0); wr(2'd3, 8'h03);
   endtask

   task automatic t_split();
      logic [7:0] h, l, f;
      wr(2'd0, 8'h0C); lo_cnt_en = 1'b1; hi_cnt_en = 1'b0;
      wr(2'd2, 8'hFE); wr(2'd1, 8'h05); rd(2'd1, h);
      chk("R9 split direct high-byte load", {8'd0, h}, 16'h0005);
      repeat (3) pulse();
      rd(2'd2, l); rd(2'd1, h);
      chk("R6 R10 low byte wraps alone", {h, l}, 16'h0501);
      rd(2'd3, f); chk("R6 no edge flag in split mode", {8'd0, f}, 16'h0000);
      lo_cnt_en = 1'b0; hi_cnt_en = 1'b1;
      pulse(); rd(2'd2, l); rd(2'd1, h);
      chk("R6 only enabled high byte counts", {h, l}, 16'h0601);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_ctrl();
      t_event();
      t_flags();
      t_load_ovf();
      t_gated();
      t_split();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule